// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter

This block is the digital model of the receive path of a differential field-bus interface that has a low-power standby state. It takes a sampled "bus is dominant" flag and drives the receive-data line toward the protocol controller, together with an enable for that line. In normal mode the receive line follows the bus. In standby it reports only dominant intervals long enough to count as a wake-up request. Short disturbances are filtered out, so the controller is woken only by real bus activity.

The mode comes from a standby-select input and from two supply undervoltage flags. A main-supply undervoltage forces standby, and the wake-up filter keeps working. An I/O-supply undervoltage forces standby, releases the receive line and suppresses every wake report. Standby may begin while the bus is stuck dominant. In that case wake reporting stays locked out until the bus has been recessive for a qualifying clear interval. A parameter removes the wake receiver entirely, and the line then stays recessive for as long as standby lasts. Both the qualifying time and the clear time are given in clock cycles.

Top module: `bus_wake_filter`

## Requirements
- R1: The bus flag (1 = dominant) passes through a SYNC_STAGES-flop synchronizer. With standby-select low (0 = normal) and both undervoltage flags low (1 = undervoltage), `rxd_o` (0 = dominant, 1 = recessive) equals the inverted synchronized bus. With the default of two stages, an input change captured at one clock edge appears after the following edge. Out of reset `rxd_o` is 1 and `rxd_oe_o` is 1.
- R2: In standby, `rxd_o` goes low only after the synchronized bus has been dominant at WAKE_CYC consecutive clock edges. Dominant pulses much shorter than that leave `rxd_o` at 1.
- R3: A synchronized dominant run of exactly WAKE_CYC-1 cycles is rejected. A run of exactly WAKE_CYC cycles produces a single low cycle of `rxd_o`.
- R4: When standby begins while the synchronized bus is dominant, `rxd_o` stays 1 in standby for as long as the lockout lasts, even if the bus stays dominant much longer than WAKE_CYC.
- R5: The lockout clears only after the synchronized bus has been recessive for CLEAR_CYC consecutive cycles. A shorter recessive gap leaves it in place. After it clears, a dominant run of WAKE_CYC cycles again drives `rxd_o` low.
- R6: After a wake report, `rxd_o` returns to 1 in the cycle after the synchronized bus goes recessive. A later report needs a new full run of WAKE_CYC dominant cycles.
- R7: A main-supply undervoltage forces standby with the wake filter active, whatever the standby-select input says.
- R8: An I/O-supply undervoltage drives `rxd_oe_o` to 0 and holds `rxd_o` at 1 in the same cycle, and no wake report is produced while it lasts.
- R9: With HAS_WAKE = 0, `rxd_o` is 1 throughout standby, and normal mode behaves as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant (asynchronous) |
| stby_sel_i | input | 1 | Mode select, 1 = standby, 0 = normal |
| uv_main_i | input | 1 | Main-supply undervoltage flag, 1 = undervoltage |
| uv_io_i | input | 1 | I/O-supply undervoltage flag, 1 = undervoltage |
| rxd_o | output | 1 | Receive data, 0 = dominant, 1 = recessive |
| rxd_oe_o | output | 1 | Drive enable for the receive line, 0 = high impedance |

## Verification
Several properties are checked on every cycle. Normal mode must mirror the bus after the synchronizer delay, and no standby wake report may appear before a full qualifying dominant run. The lockout must hold the line recessive, the line must return high one cycle after the bus goes recessive, and an I/O undervoltage must release the line. Some behaviour can only be shown by the bench's scenarios. These include the exact one-cycle boundary between WAKE_CYC-1 and WAKE_CYC dominant cycles, and a lockout that survives a recessive gap slightly short of CLEAR_CYC but clears after a longer one. They also include the forced standby under a main undervoltage and the recessive line of the variant without a wake receiver.

// File: rtl/bus_wake_pkg.sv
`timescale 1ns/1ps
package bus_wake_pkg;

   // Effective operating mode after priority resolution.
   typedef enum logic [1:0] {
      MODE_NORMAL   = 2'd0,
      MODE_STBY     = 2'd1,
      MODE_STBY_UVM = 2'd2,
      MODE_STBY_UVI = 2'd3
   } wake_mode_e;

   // Width of a counter able to hold 0..lim inclusive.
   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/bus_wake_sync.sv
`timescale 1ns/1ps
module bus_wake_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bus_wake_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q <= {STAGES{RST_VAL}};
      end else begin
         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bus_wake_runcnt.sv
`timescale 1ns/1ps
// Counts consecutive cycles with run_i high, saturating at LIMIT;
// any low cycle restarts it from zero.
module bus_wake_runcnt #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic sat_o
);
   localparam int unsigned   CW    = bus_wake_pkg::cnt_width(LIMIT);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("bus_wake_runcnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LIM_C) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sat_o = (cnt_q == LIM_C);
endmodule

// File: rtl/bus_wake_mode.sv
`timescale 1ns/1ps
// Priority: I/O undervoltage, then main undervoltage, then select input.
module bus_wake_mode (
   input  logic                    stby_sel_i,
   input  logic                    uv_main_i,
   input  logic                    uv_io_i,
   output bus_wake_pkg::wake_mode_e mode_o,
   output logic                    stby_o
);
   import bus_wake_pkg::*;

   always_comb begin
      if (uv_io_i) begin
         mode_o = MODE_STBY_UVI;
      end else if (uv_main_i) begin
         mode_o = MODE_STBY_UVM;
      end else if (stby_sel_i) begin
         mode_o = MODE_STBY;
      end else begin
         mode_o = MODE_NORMAL;
      end
   end

   assign stby_o = (mode_o != MODE_NORMAL);
endmodule

// File: rtl/bus_wake_filter.sv
`timescale 1ns/1ps
module bus_wake_filter #(
   parameter int unsigned WAKE_CYC    = 750,
   parameter int unsigned CLEAR_CYC   = 750,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_WAKE    = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bus_dom_i,
   input  logic stby_sel_i,
   input  logic uv_main_i,
   input  logic uv_io_i,
   output logic rxd_o,
   output logic rxd_oe_o
);
   import bus_wake_pkg::*;

   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("bus_wake_filter: WAKE_CYC must be at least 1");
   end
   if (CLEAR_CYC < 1) begin : g_bad_clear
      $error("bus_wake_filter: CLEAR_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bus_wake_filter: SYNC_STAGES must be at least 2");
   end

   logic       bus_s;
   logic       stby_eff;
   wake_mode_e mode;
   logic       wake_hit;
   logic       lock_w;

   bus_wake_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (bus_dom_i),
      .q_o    (bus_s)
   );

   bus_wake_mode mode_i (
      .stby_sel_i (stby_sel_i),
      .uv_main_i  (uv_main_i),
      .uv_io_i    (uv_io_i),
      .mode_o     (mode),
      .stby_o     (stby_eff)
   );

   if (HAS_WAKE) begin : g_wake
      logic dom_sat;
      logic rec_sat;
      logic stby_q;
      logic lock_q;

      bus_wake_runcnt #(.LIMIT(WAKE_CYC)) dom_cnt_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .run_i  (bus_s),
         .sat_o  (dom_sat)
      );

      bus_wake_runcnt #(.LIMIT(CLEAR_CYC)) rec_cnt_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .run_i  (!bus_s),
         .sat_o  (rec_sat)
      );

      // Lockout: armed on standby entry with the bus dominant,
      // released by a full recessive clear interval or by leaving standby.
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stby_q <= 1'b0;
            lock_q <= 1'b0;
         end else begin
            stby_q <= stby_eff;
            if (!stby_eff) begin
               lock_q <= 1'b0;
            end else if (!stby_q && bus_s) begin
               lock_q <= 1'b1;
            end else if (rec_sat) begin
               lock_q <= 1'b0;
            end
         end
      end

      assign wake_hit = stby_eff && stby_q && dom_sat && !lock_q
                        && (mode != MODE_STBY_UVI);
      assign lock_w   = lock_q;
   end else begin : g_nowake
      assign wake_hit = 1'b0;
      assign lock_w   = 1'b0;
   end

   always_comb begin
      unique case (mode)
         MODE_NORMAL:   rxd_o = !bus_s;
         MODE_STBY_UVI: rxd_o = 1'b1;
         default:       rxd_o = !wake_hit;
      endcase
   end

   assign rxd_oe_o = (mode != MODE_STBY_UVI);
endmodule

// File: rtl/bus_wake_filter_chk.sv
`timescale 1ns/1ps
module bus_wake_filter_chk #(
   parameter int unsigned WAKE_CYC    = 750,
   parameter int unsigned CLEAR_CYC   = 750,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_WAKE    = 1'b1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic bus_dom_i,
   input logic stby_sel_i,
   input logic uv_main_i,
   input logic uv_io_i,
   input logic rxd_o,
   input logic rxd_oe_o,
   input logic bus_s_i,
   input logic lock_i
);
   logic        stby_c;
   int unsigned run_q;
   logic [7:0]  warm_q;

   assign stby_c = stby_sel_i || uv_main_i || uv_io_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 0;
         warm_q <= '0;
      end else begin
         if (!bus_s_i)              run_q <= 0;
         else if (run_q < WAKE_CYC) run_q <= run_q + 1;
         if (warm_q != 8'hFF)       warm_q <= warm_q + 8'd1;
      end
   end

   if (SYNC_STAGES == 2) begin : g_mirror
      AST_NORMAL_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!stby_c && warm_q >= 8'd2) |-> (rxd_o == !$past(bus_dom_i, 2))); // R1
   end

   AST_NO_EARLY_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stby_c && !rxd_o) |-> (run_q >= WAKE_CYC)); // R2

   AST_LOCK_HOLDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stby_c && lock_i) |-> rxd_o); // R4

   AST_RELEASE_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stby_c && !bus_s_i) |=> (rxd_o || !stby_c)); // R6

   AST_UVMAIN_FILTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uv_main_i && !rxd_o) |-> (run_q >= WAKE_CYC)); // R7

   AST_UVIO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_io_i |-> (!rxd_oe_o && rxd_o)); // R8

   AST_OE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !uv_io_i |-> rxd_oe_o); // R8

   if (!HAS_WAKE) begin : g_nowake_chk
      AST_NOWAKE_RECESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         stby_c |-> rxd_o); // R9
   end
endmodule

bind bus_wake_filter bus_wake_filter_chk #(
   .WAKE_CYC    (WAKE_CYC),
   .CLEAR_CYC   (CLEAR_CYC),
   .SYNC_STAGES (SYNC_STAGES),
   .HAS_WAKE    (HAS_WAKE)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_dom_i  (bus_dom_i),
   .stby_sel_i (stby_sel_i),
   .uv_main_i  (uv_main_i),
   .uv_io_i    (uv_io_i),
   .rxd_o      (rxd_o),
   .rxd_oe_o   (rxd_oe_o),
   .bus_s_i    (bus_s),
   .lock_i     (lock_w)
);

// File: tb/bus_wake_filter_tb_top.sv
`timescale 1ns/1ps
module bus_wake_filter_tb_top;
   localparam int unsigned W = 750;
   localparam int unsigned C = 750;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus = 1'b0, stby = 1'b0, uvm = 1'b0, uvi = 1'b0;
   logic rxd, oe, rxd_nw, oe_nw;

   always #2 clk = ~clk;   // 250 MHz

   bus_wake_filter #(.WAKE_CYC(W), .CLEAR_CYC(C), .SYNC_STAGES(2), .HAS_WAKE(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_dom_i(bus), .stby_sel_i(stby),
      .uv_main_i(uvm), .uv_io_i(uvi), .rxd_o(rxd), .rxd_oe_o(oe));

   bus_wake_filter #(.WAKE_CYC(W), .CLEAR_CYC(C), .SYNC_STAGES(2), .HAS_WAKE(1'b0)) dut_nw_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_dom_i(bus), .stby_sel_i(stby),
      .uv_main_i(uvm), .uv_io_i(uvi), .rxd_o(rxd_nw), .rxd_oe_o(oe_nw));

   typedef struct {
      int unsigned cyc;
      logic        rxd;
      logic        oe;
      bit          nw;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int unsigned cyc = 0;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Driver side: push an expectation dly cycles ahead, kept in time order.
   task automatic expect_at(input int unsigned dly, input logic r, input logic e,
                            input bit nw, input string tag);
      exp_t it;
      int   pos;
      it.cyc = cyc + dly; it.rxd = r; it.oe = e; it.nw = nw; it.tag = tag;
      pos = sb_q.size();
      for (int i = 0; i < sb_q.size(); i++) begin
         if (sb_q[i].cyc > it.cyc) begin
            pos = i;
            break;
         end
      end
      sb_q.insert(pos, it);
   endtask

   task automatic tick(input int unsigned n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   // Monitor: pops due items at each falling edge and compares.
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
         exp_t it;
         logic ar, ae;
         it = sb_q.pop_front();
         ar = it.nw ? rxd_nw : rxd;
         ae = it.nw ? oe_nw : oe;
         checks++;
         if (it.cyc != cyc || ar !== it.rxd || ae !== it.oe) begin
            fails++;
            $display("FAIL %s cyc=%0d: actual rxd=%b oe=%b expected rxd=%b oe=%b (due %0d)",
                     it.tag, cyc, ar, ae, it.rxd, it.oe, it.cyc);
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      // Reset state
      tick(5);
      rst_n = 1'b1;
      expect_at(1, 1'b1, 1'b1, 1'b0, "R1 reset");
      expect_at(1, 1'b1, 1'b1, 1'b1, "R1 reset variant");
      tick(4);

      // R1: normal mode mirrors after the synchronizer
      bus = 1'b1;
      expect_at(1, 1'b1, 1'b1, 1'b0, "R1 latency");
      expect_at(2, 1'b0, 1'b1, 1'b0, "R1 dominant");
      expect_at(2, 1'b0, 1'b1, 1'b1, "R9 variant normal");
      tick(8);
      bus = 1'b0;
      expect_at(1, 1'b0, 1'b1, 1'b0, "R1 latency");
      expect_at(2, 1'b1, 1'b1, 1'b0, "R1 recessive");
      tick(4);
      bus = 1'b1;
      expect_at(2, 1'b0, 1'b1, 1'b0, "R1 one-cycle pulse");
      expect_at(3, 1'b1, 1'b1, 1'b0, "R1 one-cycle pulse end");
      tick(1);
      bus = 1'b0;
      tick(6);

      // R2: standby rejects short pulses
      stby = 1'b1;
      tick(10);
      bus = 1'b1;
      expect_at(2, 1'b1, 1'b1, 1'b0, "R2 short");
      expect_at(100, 1'b1, 1'b1, 1'b0, "R2 short");
      expect_at(176, 1'b1, 1'b1, 1'b0, "R2 short");
      tick(175);
      bus = 1'b0;
      tick(10);

      // R3: boundary runs
      bus = 1'b1;
      expect_at(W + 1, 1'b1, 1'b1, 1'b0, "R3 run W-1");
      expect_at(W + 2, 1'b1, 1'b1, 1'b0, "R3 run W-1");
      tick(W - 1);
      bus = 1'b0;
      tick(20);
      bus = 1'b1;
      expect_at(W + 1, 1'b1, 1'b1, 1'b0, "R3 run W before");
      expect_at(W + 2, 1'b0, 1'b1, 1'b0, "R3 run W hit");
      expect_at(W + 3, 1'b1, 1'b1, 1'b0, "R6 release");
      expect_at(W + 2, 1'b1, 1'b1, 1'b1, "R9 variant boundary");
      tick(W);
      bus = 1'b0;
      tick(20);

      // R2/R6/R9: long pulse, release, then a fresh interval needed
      bus = 1'b1;
      expect_at(W + 2, 1'b0, 1'b1, 1'b0, "R2 long");
      expect_at(1000, 1'b0, 1'b1, 1'b0, "R2 long held");
      expect_at(1000, 1'b1, 1'b1, 1'b1, "R9 variant long");
      expect_at(1252, 1'b0, 1'b1, 1'b0, "R6 last low");
      expect_at(1253, 1'b1, 1'b1, 1'b0, "R6 release");
      tick(1250);
      bus = 1'b0;
      tick(10);
      bus = 1'b1;
      expect_at(150, 1'b1, 1'b1, 1'b0, "R6 rearm");
      expect_at(202, 1'b1, 1'b1, 1'b0, "R6 rearm");
      tick(200);
      bus = 1'b0;
      tick(10);

      // R4/R5: standby entered with the bus stuck dominant
      stby = 1'b0;
      tick(5);
      bus = 1'b1;
      tick(20);
      stby = 1'b1;
      expect_at(1, 1'b1, 1'b1, 1'b0, "R4 entry");
      expect_at(2, 1'b1, 1'b1, 1'b0, "R4 locked");
      expect_at(1500, 1'b1, 1'b1, 1'b0, "R4 locked long");
      tick(2000);
      bus = 1'b0;
      tick(C - 10);
      bus = 1'b1;
      expect_at(W + 2, 1'b1, 1'b1, 1'b0, "R5 short gap keeps lock");
      expect_at(1400, 1'b1, 1'b1, 1'b0, "R5 short gap keeps lock");
      tick(1500);
      bus = 1'b0;
      tick(C + 20);
      bus = 1'b1;
      expect_at(W + 1, 1'b1, 1'b1, 1'b0, "R5 cleared before");
      expect_at(W + 2, 1'b0, 1'b1, 1'b0, "R5 cleared wake");
      tick(W + 50);
      bus = 1'b0;
      tick(10);

      // R7: main undervoltage forces filtered standby
      stby = 1'b0;
      tick(10);
      uvm = 1'b1;
      expect_at(2, 1'b1, 1'b1, 1'b0, "R7 enter");
      tick(5);
      bus = 1'b1;
      expect_at(2, 1'b1, 1'b1, 1'b0, "R7 not mirrored");
      expect_at(W + 1, 1'b1, 1'b1, 1'b0, "R7 before");
      expect_at(W + 2, 1'b0, 1'b1, 1'b0, "R7 wake");
      tick(W + 10);
      bus = 1'b0;
      tick(10);
      uvm = 1'b0;
      tick(5);

      // R8: I/O undervoltage releases the line and blocks wake
      uvi = 1'b1;
      expect_at(1, 1'b1, 1'b0, 1'b0, "R8 release");
      tick(5);
      bus = 1'b1;
      expect_at(2, 1'b1, 1'b0, 1'b0, "R8 no mirror");
      expect_at(W + 2, 1'b1, 1'b0, 1'b0, "R8 wake blocked");
      expect_at(W + 50, 1'b1, 1'b0, 1'b0, "R8 wake blocked");
      tick(W + 100);
      bus = 1'b0;
      tick(10);
      uvi = 1'b0;
      expect_at(1, 1'b1, 1'b1, 1'b0, "R8 drive restored");
      tick(20);

      if (sb_q.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
      end
      done = 1'b1;
      finish_run();
   end
endmodule